// File: doc/BRIEF.md
# Flow-through zero-turnaround synchronous SRAM

This block is a synthesizable model of a small single-port synchronous SRAM built so that reads and writes can follow each other in any mix with a data transfer on every clock. Address and control are registered on the rising edge. A read is flow-through: after the edge that accepts the read, the stored word appears on the output within that same cycle. Write data trails its address by one clock. The address and byte mask are held in a write register until the data edge, so a read issued in the cycle after a write uses the bus in the same slot that a read would, and the bus never needs a turnaround gap.

Bursts of up to four words are started by a load and continued by advance cycles. The two low address bits step either in linear order or in interleaved (XOR) order, chosen by a static mode pin. A clock enable freezes all state. Two synchronous chip selects gate new loads, an asynchronous output enable gates only the drivers, and a sleep input blocks all activity. The bidirectional data bus is split into `din`, `dout` and `dout_en`.

Top module: `zbt_flow_sram`

## Requirements
- R1: A read load (adv_ld=0, chip selected, we=0) captured at a rising edge drives the stored word at that address on `dout` with `dout_en`=1 during the cycle that follows the edge.
- R2: While `clk_en` is 0, a rising edge changes no state: no write is committed, `din` is not sampled, and `dout`/`dout_en` keep their values.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle, and every read returns the correct data.
- R4: On a write, bit i of `byte_we` enables lane i, which is bits [9i+8:9i] of the word. Lanes whose bit is 0 keep their old contents.
- R5: Write data is sampled on `din` at the edge after the one that captured the write address. During the cycle between those edges `dout_en` is 0. A read of the same address loaded at the data edge returns the new data.
- R6: With `burst_ilv`=0, each advance edge (adv_ld=1) sets the low two address bits to (start + n) mod 4, where n is the advance count since the load. The upper bits stay fixed. Chip selects are ignored on advance edges.
- R7: With `burst_ilv`=1, each advance edge sets the low two address bits to start XOR n.
- R8: A load edge with the chip deselected (`chip_sel`=0 or `chip_sel_n`=1) starts no operation. `dout_en` goes to 0 and no write is committed.
- R9: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge, and changes no other state.
- R10: An edge with `sleep`=1 starts no operation and commits no write. `dout_en` is 0 while `sleep` is 1.
- R11: After reset `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| clk_en | input | 1 | Clock qualifier; 0 freezes the block |
| chip_sel | input | 1 | Active-high synchronous chip select |
| chip_sel_n | input | 1 | Active-low synchronous chip select |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new address |
| we | input | 1 | 1 = write, 0 = read, taken on a load |
| byte_we | input | LANES | Per-lane write enable |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Power-down: 1 ignores all operations |
| din | input | LANES*LANE_W | Write data, one clock after the address |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Output driver enable for the shared bus |

## Verification
The bench targets the write-then-read hazard at one address. A model that needs a spare cycle, or that reads the array before the commit, would return stale data on the read that follows. Bursts are started from a middle address in both orders, so a counter that did not wrap, or that mixed the linear and XOR stepping, gives the wrong word sequence. A write whose data edge falls while `clk_en` is low checks that a frozen edge does not sample `din`. Sleep and deselect loads are each followed by a read-back, which shows a leaking write as corrupted contents. The partial byte write shows lane decoding errors as wrong bits in the merged word.

// File: rtl/zbt_flow_sram.sv
module zbt_flow_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     chip_sel,
  input  logic                     chip_sel_n,
  input  logic                     adv_ld,
  input  logic                     we,
  input  logic [LANES-1:0]         byte_we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     burst_ilv,
  input  logic                     oe_n,
  input  logic                     sleep,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} op_t;

  logic [DATA_W-1:0] mem [DEPTH];
  op_t               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        start_q, start_d, cnt_q, cnt_d;
  logic [LANES-1:0]  mask_q;
  logic              selected;

  assign selected = chip_sel & ~chip_sel_n;

  always_comb begin
    op_d    = op_q;
    addr_d  = addr_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (sleep) begin
      op_d = OP_IDLE;
    end else if (adv_ld) begin
      cnt_d  = cnt_q + 2'd1;
      addr_d = {addr_q[ADDR_W-1:2], burst_ilv ? (start_q ^ cnt_d) : (start_q + cnt_d)};
    end else if (selected) begin
      op_d    = we ? OP_WR : OP_RD;
      addr_d  = addr;
      start_d = addr[1:0];
      cnt_d   = 2'd0;
    end else begin
      op_d = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else if (clk_en) begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      mask_q  <= byte_we;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && !sleep && op_q == OP_WR) begin
      for (int i = 0; i < LANES; i++) begin
        if (mask_q[i]) mem[addr_q][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
      end
    end
  end

  assign dout    = mem[addr_q];
  assign dout_en = (op_q == OP_RD) & ~oe_n & ~sleep;

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(op_q) && $stable(addr_q) && $stable(cnt_q)));

  assert_wr_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WR) |-> !dout_en);

  assert_burst_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && adv_ld) |=> (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

  assert_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv_ld && !selected) |=> !dout_en);

  assert_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  assert_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> (op_q == OP_IDLE));
endmodule

// File: tb/zbt_flow_sram_tb.sv
module zbt_flow_sram_tb;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0, clk_en = 1, chip_sel = 0, chip_sel_n = 0;
  logic adv_ld = 0, we = 0, burst_ilv = 0, oe_n = 0, sleep = 0;
  logic [3:0] byte_we = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic dout_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  zbt_flow_sram u_dut (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel(chip_sel),
    .chip_sel_n(chip_sel_n), .adv_ld(adv_ld), .we(we), .byte_we(byte_we), .addr(addr),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en));

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return 36'h5A5A00000 | DW'(a) | (DW'(a) << 12);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic w, input logic [AW-1:0] a, input logic [3:0] be);
    adv_ld = 0; chip_sel = 1; we = w; addr = a; byte_we = be;
  endtask

  task automatic idle();
    adv_ld = 0; chip_sel = 0; we = 0;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] be);
    load(1, a, be); step();
    din = d; idle(); step();
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    load(0, a, 4'h0); step();
    chk(req, dout, exp); chk(req, DW'(dout_en), 1);
    idle(); step();
  endtask

  task automatic t_reset();
    chk("R11", DW'(dout_en), 0);
  endtask

  task automatic t_mix();
    load(1, 8'h10, 4'hF); step();
    chk("R5", DW'(dout_en), 0);
    din = 36'h111111111; load(0, 8'h10, 4'h0); step();
    chk("R5", dout, 36'h111111111); chk("R1", DW'(dout_en), 1);
    load(1, 8'h20, 4'hF); step();
    chk("R3", DW'(dout_en), 0);
    din = 36'h222222222; load(0, 8'h10, 4'h0); step();
    chk("R3", dout, 36'h111111111);
    load(1, 8'h21, 4'hF); step();
    din = 36'h333333333; load(0, 8'h20, 4'h0); step();
    chk("R3", dout, 36'h222222222);
    load(0, 8'h21, 4'h0); step();
    chk("R3", dout, 36'h333333333);
    idle(); step();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] oldv = 36'h123456789, newv = 36'hFEDCBA987, m = 36'h007FC01FF;
    write_word(8'h30, oldv, 4'hF);
    write_word(8'h30, newv, 4'b0101);
    read_check("R4", 8'h30, (newv & m) | (oldv & ~m));
  endtask

  task automatic t_cen();
    load(0, 8'h21, 4'h0); step();
    clk_en = 0; load(0, 8'h10, 4'h0); step();
    chk("R2", dout, 36'h333333333); chk("R2", DW'(dout_en), 1);
    clk_en = 1; idle(); step();
    load(1, 8'h40, 4'hF); step();
    din = 36'hBADBADBAD; clk_en = 0; idle(); step();
    din = 36'h0C0FFEE00; clk_en = 1; step();
    read_check("R2", 8'h40, 36'h0C0FFEE00);
  endtask

  task automatic t_burst(input logic ilv, input logic [AW-1:0] s, input string req);
    burst_ilv = ilv;
    load(0, s, 4'h0); step();
    chk(req, dout, pat(s));
    for (int n = 1; n < 4; n++) begin
      adv_ld = 1; chip_sel = 0; step();
      chk(req, dout, pat({s[AW-1:2], ilv ? (s[1:0] ^ 2'(n)) : (s[1:0] + 2'(n))}));
    end
    idle(); burst_ilv = 0; step();
  endtask

  task automatic t_desel();
    load(1, 8'h52, 4'hF); chip_sel_n = 1; step();
    chk("R8", DW'(dout_en), 0);
    chip_sel_n = 0; din = 36'hDEADDEAD0; idle(); step();
    read_check("R8", 8'h52, pat(8'h52));
  endtask

  task automatic t_oe();
    oe_n = 1; load(0, 8'h50, 4'h0); step();
    chk("R9", DW'(dout_en), 0); chk("R9", dout, pat(8'h50));
    oe_n = 0; #1;
    chk("R9", DW'(dout_en), 1);
    idle(); step();
  endtask

  task automatic t_sleep();
    load(0, 8'h51, 4'h0); step();
    sleep = 1; #1;
    chk("R10", DW'(dout_en), 0);
    load(1, 8'h53, 4'hF); step();
    din = 36'hFFFFFFFFF; idle(); step();
    sleep = 0;
    read_check("R10", 8'h53, pat(8'h53));
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_mix();
    t_bytes();
    t_cen();
    for (int a = 8'h50; a < 8'h54; a++) write_word(AW'(a), pat(AW'(a)), 4'hF);
    t_burst(0, 8'h52, "R6");
    t_burst(1, 8'h51, "R7");
    t_desel();
    t_oe();
    t_sleep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule